// File: doc/BRIEF.md
# SATA Channel Bring-Up Sequencer

This block powers up one PATA-to-SATA adapter channel and reports whether the link came up. A start request turns the channel clock on, waits for the clock to settle, writes the channel control bits, gives the PHY a settling period, and then polls the PHY-ready status at a coarse interval until it is seen high or an overall deadline runs out. The outcome is held on `online`, and `done` pulses once when the sequence ends. If a start sequence fails, the channel clock is switched back off.

A reset request runs a shorter variant. It pulses the channel reset for one cycle, waits, and then repeats the control write and polling, leaving the clock enable as it was. A stop request only switches the clock off. Every wait is counted in milliseconds from a restartable prescaler. `CLK_PER_MS` sets the prescaler, so a test can use a small divisor. Two instances (`CHAN_ID` 0 and 1) share the same routing mode. The routing mode decides which of them runs its adapter as a slave device.

Top module: `sata_chan_bringup`

## Requirements
- R1: While `rst_n` is low at a clock edge, every output is low after that edge.
- R2: A start request accepted in idle sets `clk_en` at the accepting edge. `ctrl_en` and `hotplug_en` are both set `SETTLE_MS*CLK_PER_MS+1` cycles later, and every control write sets both of them.
- R3: `route_mode` is a 3-bit field sampled when a request is accepted. At the control write, channel 0 sets `slave_en` only for mode 2, and channel 1 only for mode 3. In every other mode `slave_en` is low.
- R4: After the control write there is a `SETTLE_MS` wait, and then `phy_ready` is sampled at the end of each `POLL_MS` window. Each wait of N ms lasts N*CLK_PER_MS+1 cycles. The first high sample ends the sequence with `online` high.
- R5: If none of the ceil(DEADLINE_MS/POLL_MS) samples is high, the sequence ends with `online` low.
- R6: A start sequence that ends with `online` low clears `clk_en` on the same edge that raises `done`.
- R7: A reset request accepted in idle drives `chan_rst` high for exactly one cycle. A `SETTLE_MS` wait follows, then the control write and polling of R2 to R5. `clk_en` never changes during this sequence, whether it succeeds or fails.
- R8: A stop request in idle, when neither start nor reset is accepted, clears `clk_en` and leaves `ctrl_en`, `slave_en` and `online` unchanged.
- R9: A start request while `route_mode` is 4 to 7 is ignored. The block stays idle and `clk_en` does not change.
- R10: `busy` is high from the accepting edge to the end of the sequence. `done` is high for exactly one cycle, in the first idle cycle, with `online` holding the last sample. `online` is cleared when a sequence is accepted.
- R11: Requests that arrive while `busy` is high are ignored. In idle, start has priority over reset, and reset has priority over stop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_req | input | 1 | Request a full bring-up |
| stop_req | input | 1 | Request that the channel clock be turned off |
| reset_req | input | 1 | Request a channel reset and re-link |
| route_mode | input | 3 | Adapter routing mode (4 to 7 reserved) |
| phy_ready | input | 1 | PHY link-ready status |
| clk_en | output | 1 | Channel peripheral clock enable |
| chan_rst | output | 1 | One-cycle channel reset pulse |
| ctrl_en | output | 1 | Channel enable control bit |
| hotplug_en | output | 1 | Hot-plug detect enable control bit |
| slave_en | output | 1 | Slave-device enable control bit |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle end-of-sequence pulse |
| online | output | 1 | Result of the last sequence |

## Verification
An internal fault in this block shows at the ports mostly as a timing error. A wait counter that restarts wrongly moves the cycle of the `done` pulse by a whole millisecond or a whole poll window. A poll counter that is off by one ends a failing run one window early or late. So the cycle count from request to `done` is the sharpest observation, and it becomes visible at the end of the sequence. A wrong latched mode or a wrong path flag appears sooner: a wrong `slave_en` shows at the control write, and a misplaced `clk_en` shows at the `done` edge of a failed start or at any edge of a reset sequence.

// File: rtl/sbu_pkg.sv
// Shared types and helpers for the SATA channel bring-up sequencer.
// Assumes a 3-bit routing mode whose upper half (4..7) is reserved.
package sbu_pkg;
    localparam int MODE_W = 3;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CLK_WAIT,
        ST_RST_PULSE,
        ST_RST_WAIT,
        ST_SETTLE,
        ST_POLL
    } sbu_state_e;

    typedef struct packed {
        logic chan_en;
        logic hp_en;
        logic slave;
    } sbu_ctrl_t;

    // True when the routing mode is in the reserved range.
    function automatic logic mode_reserved(input logic [MODE_W-1:0] m);
        return m[MODE_W-1];
    endfunction
endpackage

// File: rtl/sbu_prescaler.sv
// Millisecond prescaler: emits one tick every CLK_PER_MS cycles.
// Assumes restart zeroes the phase so that each wait starts aligned.
module sbu_prescaler #(
    parameter int CLK_PER_MS = 125000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    output logic tick
);
    localparam int CW = (CLK_PER_MS > 1) ? $clog2(CLK_PER_MS) : 1;
    localparam logic [CW-1:0] LAST = CW'(CLK_PER_MS - 1);

    logic [CW-1:0] cnt_q;

    // Cycle counter, wraps at LAST, zeroed on restart.
    always_ff @(posedge clk) begin
        if (!rst_n || restart) begin
            cnt_q <= '0;
        end else if (cnt_q == LAST) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign tick = (cnt_q == LAST);
endmodule

// File: rtl/sbu_ms_timer.sv
// Millisecond counter compared against a target given by the sequencer.
// Assumes target stays constant between restarts; counting stops at target.
module sbu_ms_timer #(
    parameter int MS_W = 7
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            restart,
    input  logic            tick,
    input  logic [MS_W-1:0] target,
    output logic            expired
);
    logic [MS_W-1:0] ms_q;

    assign expired = (ms_q == target);

    // Elapsed milliseconds since the last restart, saturating at target.
    always_ff @(posedge clk) begin
        if (!rst_n || restart) begin
            ms_q <= '0;
        end else if (tick && !expired) begin
            ms_q <= ms_q + 1'b1;
        end
    end
endmodule

// File: rtl/sbu_ctrl_reg.sv
// Channel control bit register, loaded once per sequence.
// Assumes mode_lat is the mode captured when the sequence was accepted.
module sbu_ctrl_reg
    import sbu_pkg::*;
#(
    parameter int CHAN_ID = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [MODE_W-1:0] mode_lat,
    output sbu_ctrl_t         ctrl
);
    logic slave_sel;

    // Per-channel slave decode: only one mode makes each channel a slave.
    generate
        if (CHAN_ID == 0) begin : g_chan0
            assign slave_sel = (mode_lat == MODE_W'(2));
        end else begin : g_chan1
            assign slave_sel = (mode_lat == MODE_W'(3));
        end
    endgenerate

    // Write the full control word on each load.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl <= '0;
        end else if (load) begin
            ctrl.chan_en <= 1'b1;
            ctrl.hp_en   <= 1'b1;
            ctrl.slave   <= slave_sel;
        end
    end
endmodule

// File: rtl/sbu_fsm.sv
// Bring-up sequence controller: request arbitration, waits, polling, result.
// Assumes the timer raises expired once target ms have passed since restart.
module sbu_fsm
    import sbu_pkg::*;
#(
    parameter int SETTLE_MS = 10,
    parameter int POLL_MS   = 100,
    parameter int NUM_POLLS = 10,
    parameter int MS_W      = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_req,
    input  logic              stop_req,
    input  logic              reset_req,
    input  logic [MODE_W-1:0] route_mode,
    input  logic              phy_ready,
    input  logic              expired,
    output logic              restart,
    output logic [MS_W-1:0]   target,
    output logic              ctrl_load,
    output logic [MODE_W-1:0] mode_lat,
    output logic              from_start,
    output logic              clk_en,
    output logic              chan_rst,
    output logic              busy,
    output logic              done,
    output logic              online
);
    localparam int PW = (NUM_POLLS > 1) ? $clog2(NUM_POLLS) : 1;
    localparam logic [PW-1:0]   LAST_POLL = PW'(NUM_POLLS - 1);
    localparam logic [MS_W-1:0] T_SETTLE  = MS_W'(SETTLE_MS);
    localparam logic [MS_W-1:0] T_POLL    = MS_W'(POLL_MS);

    sbu_state_e    state_q, state_d;
    logic [PW-1:0] poll_q;
    logic          idle, take_start, take_reset, take_stop, poll_end;

    // Request arbitration in idle: start, then reset, then stop.
    always_comb begin
        idle       = (state_q == ST_IDLE);
        take_start = idle && start_req && !mode_reserved(route_mode);
        take_reset = idle && !take_start && reset_req;
        take_stop  = idle && !take_start && !take_reset && stop_req;
        poll_end   = (state_q == ST_POLL) && expired &&
                     (phy_ready || (poll_q == LAST_POLL));
    end

    // Next state, timer control and control-word load.
    always_comb begin
        state_d   = state_q;
        restart   = 1'b0;
        ctrl_load = 1'b0;
        target    = T_SETTLE;
        case (state_q)
            ST_IDLE: begin
                if (take_start) begin
                    state_d = ST_CLK_WAIT;
                    restart = 1'b1;
                end else if (take_reset) begin
                    state_d = ST_RST_PULSE;
                end
            end
            ST_CLK_WAIT, ST_RST_WAIT: begin
                if (expired) begin
                    state_d   = ST_SETTLE;
                    restart   = 1'b1;
                    ctrl_load = 1'b1;
                end
            end
            ST_RST_PULSE: begin
                state_d = ST_RST_WAIT;
                restart = 1'b1;
            end
            ST_SETTLE: begin
                if (expired) begin
                    state_d = ST_POLL;
                    restart = 1'b1;
                end
            end
            ST_POLL: begin
                target = T_POLL;
                if (expired) begin
                    restart = 1'b1;
                    if (poll_end) begin
                        state_d = ST_IDLE;
                    end
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // State register and poll-window counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            poll_q  <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_SETTLE) begin
                poll_q <= '0;
            end else if ((state_q == ST_POLL) && expired && !poll_end) begin
                poll_q <= poll_q + 1'b1;
            end
        end
    end

    // Registered outputs: clock gate, reset pulse, result and sequence context.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            clk_en     <= 1'b0;
            chan_rst   <= 1'b0;
            done       <= 1'b0;
            online     <= 1'b0;
            mode_lat   <= '0;
            from_start <= 1'b0;
        end else begin
            chan_rst <= 1'b0;
            done     <= 1'b0;
            if (take_start) begin
                clk_en     <= 1'b1;
                online     <= 1'b0;
                mode_lat   <= route_mode;
                from_start <= 1'b1;
            end else if (take_reset) begin
                chan_rst   <= 1'b1;
                online     <= 1'b0;
                mode_lat   <= route_mode;
                from_start <= 1'b0;
            end else if (take_stop) begin
                clk_en <= 1'b0;
            end
            if (poll_end) begin
                done   <= 1'b1;
                online <= phy_ready;
                if (!phy_ready && from_start) begin
                    clk_en <= 1'b0;
                end
            end
        end
    end

    assign busy = !idle;
endmodule

// File: rtl/sata_chan_bringup.sv
// Top of the per-channel SATA adapter bring-up sequencer.
// Assumes one instance per channel; CHAN_ID selects the slave-mode decode.
module sata_chan_bringup
    import sbu_pkg::*;
#(
    parameter int CHAN_ID     = 0,
    parameter int CLK_PER_MS  = 125000,
    parameter int SETTLE_MS   = 10,
    parameter int POLL_MS     = 100,
    parameter int DEADLINE_MS = 1000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start_req,
    input  logic       stop_req,
    input  logic       reset_req,
    input  logic [2:0] route_mode,
    input  logic       phy_ready,
    output logic       clk_en,
    output logic       chan_rst,
    output logic       ctrl_en,
    output logic       hotplug_en,
    output logic       slave_en,
    output logic       busy,
    output logic       done,
    output logic       online
);
    localparam int NUM_POLLS = (DEADLINE_MS + POLL_MS - 1) / POLL_MS;
    localparam int MAX_MS    = (SETTLE_MS > POLL_MS) ? SETTLE_MS : POLL_MS;
    localparam int MS_W      = $clog2(MAX_MS + 1);

    logic              tick, restart, expired, ctrl_load, from_start;
    logic [MS_W-1:0]   target;
    logic [MODE_W-1:0] mode_lat;
    sbu_ctrl_t         ctrl;

    sbu_prescaler #(.CLK_PER_MS(CLK_PER_MS)) u_presc (
        .clk(clk), .rst_n(rst_n), .restart(restart), .tick(tick)
    );

    sbu_ms_timer #(.MS_W(MS_W)) u_timer (
        .clk(clk), .rst_n(rst_n), .restart(restart), .tick(tick),
        .target(target), .expired(expired)
    );

    sbu_fsm #(
        .SETTLE_MS(SETTLE_MS), .POLL_MS(POLL_MS),
        .NUM_POLLS(NUM_POLLS), .MS_W(MS_W)
    ) u_fsm (
        .clk(clk), .rst_n(rst_n),
        .start_req(start_req), .stop_req(stop_req), .reset_req(reset_req),
        .route_mode(route_mode), .phy_ready(phy_ready), .expired(expired),
        .restart(restart), .target(target), .ctrl_load(ctrl_load),
        .mode_lat(mode_lat), .from_start(from_start),
        .clk_en(clk_en), .chan_rst(chan_rst), .busy(busy),
        .done(done), .online(online)
    );

    sbu_ctrl_reg #(.CHAN_ID(CHAN_ID)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .load(ctrl_load),
        .mode_lat(mode_lat), .ctrl(ctrl)
    );

    assign ctrl_en    = ctrl.chan_en;
    assign hotplug_en = ctrl.hp_en;
    assign slave_en   = ctrl.slave;
endmodule

// File: rtl/sbu_checker.sv
// Property checker for sata_chan_bringup, attached by bind below.
// Assumes it sees the top-level ports plus the latched mode and path flag.
module sbu_checker
    import sbu_pkg::*;
#(
    parameter int CHAN_ID = 0
) (
    input logic       clk,
    input logic       rst_n,
    input logic       start_req,
    input logic       stop_req,
    input logic       reset_req,
    input logic [2:0] route_mode,
    input logic       clk_en,
    input logic       chan_rst,
    input logic       ctrl_en,
    input logic       hotplug_en,
    input logic       slave_en,
    input logic       busy,
    input logic       done,
    input logic       online,
    input logic [2:0] mode_lat,
    input logic       from_start
);
    localparam logic [2:0] SLV_MODE = (CHAN_ID == 0) ? 3'd2 : 3'd3;

    assert_slave_with_ctrl_R2: assert property (@(posedge clk) disable iff (!rst_n)
        slave_en |-> (ctrl_en && hotplug_en));

    assert_slave_mode_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(slave_en) |-> (mode_lat == SLV_MODE));

    assert_fail_gates_clock_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !online && from_start) |-> !clk_en);

    assert_rst_pulse_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        chan_rst |=> !chan_rst);

    assert_reset_keeps_clock_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !from_start) |=> $stable(clk_en));

    assert_stop_clears_clock_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && stop_req && !reset_req && (!start_req || mode_reserved(route_mode)))
        |=> !clk_en);

    assert_reserved_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start_req && mode_reserved(route_mode) && !reset_req) |=> !busy);

    assert_done_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_done_at_end_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done);
endmodule

bind sata_chan_bringup sbu_checker #(.CHAN_ID(CHAN_ID)) u_sbu_checker (
    .clk(clk), .rst_n(rst_n), .start_req(start_req), .stop_req(stop_req),
    .reset_req(reset_req), .route_mode(route_mode), .clk_en(clk_en),
    .chan_rst(chan_rst), .ctrl_en(ctrl_en), .hotplug_en(hotplug_en),
    .slave_en(slave_en), .busy(busy), .done(done), .online(online),
    .mode_lat(mode_lat), .from_start(from_start)
);

// File: tb/tb_sata_chan_bringup.sv
// Scoreboard bench: launch tasks queue the expected end-of-sequence result,
// a monitor pops it at each done pulse and compares ports and latency.
module tb_sata_chan_bringup;
    localparam int P     = 4;
    localparam int W10   = 10 * P + 1;
    localparam int WPOLL = 100 * P + 1;
    localparam int NPOLL = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start_req = 1'b0, stop_req = 1'b0, reset_req = 1'b0;
    logic [2:0] route_mode = 3'd0;
    logic       phy_ready;
    logic       clk_en, chan_rst, ctrl_en, hotplug_en, slave_en, busy, done, online;
    logic       clk_en1, chan_rst1, ctrl_en1, hotplug_en1, slave_en1, busy1, done1, online1;

    int cyc = 0;
    int ready_at = 32'h3fff_ffff;
    int t_acc = 0;
    int n_chk = 0;
    int n_bad = 0;

    typedef struct {
        string tag;
        int    lat;
        bit    onl;
        bit    ck;
        bit    s0;
        bit    s1;
    } exp_t;
    exp_t exp_q[$];

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;
    assign phy_ready = (cyc >= ready_at);

    sata_chan_bringup #(.CHAN_ID(0), .CLK_PER_MS(P)) dut (
        .clk(clk), .rst_n(rst_n), .start_req(start_req), .stop_req(stop_req),
        .reset_req(reset_req), .route_mode(route_mode), .phy_ready(phy_ready),
        .clk_en(clk_en), .chan_rst(chan_rst), .ctrl_en(ctrl_en),
        .hotplug_en(hotplug_en), .slave_en(slave_en), .busy(busy),
        .done(done), .online(online)
    );

    sata_chan_bringup #(.CHAN_ID(1), .CLK_PER_MS(P)) dut1 (
        .clk(clk), .rst_n(rst_n), .start_req(start_req), .stop_req(stop_req),
        .reset_req(reset_req), .route_mode(route_mode), .phy_ready(phy_ready),
        .clk_en(clk_en1), .chan_rst(chan_rst1), .ctrl_en(ctrl_en1),
        .hotplug_en(hotplug_en1), .slave_en(slave_en1), .busy(busy1),
        .done(done1), .online(online1)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Queue the expected result and issue one request (is_rst: reset path).
    // k is the poll sample at which the PHY is first high, 0 for never.
    task automatic launch(input bit is_rst, input bit with_stop, input logic [2:0] m,
                          input int k, input string tag, input bit e_ck,
                          input bit e_s0, input bit e_s1);
        exp_t e;
        int   base;
        base  = (is_rst ? 1 : 0) + 2 * W10;
        e.tag = tag;
        e.lat = base + ((k == 0) ? NPOLL : k) * WPOLL;
        e.onl = (k != 0);
        e.ck  = e_ck;
        e.s0  = e_s0;
        e.s1  = e_s1;
        exp_q.push_back(e);
        @(negedge clk);
        t_acc      = cyc + 1;
        ready_at   = (k == 0) ? 32'h3fff_ffff : t_acc + base + k * WPOLL - 50;
        route_mode = m;
        start_req  = !is_rst;
        reset_req  = is_rst;
        stop_req   = with_stop;
        @(negedge clk);
        start_req = 1'b0;
        reset_req = 1'b0;
        stop_req  = 1'b0;
    endtask

    task automatic wait_done();
        while (exp_q.size() != 0) @(negedge clk);
        @(negedge clk);
    endtask

    // Monitor: compare each finished sequence against the queued item.
    always @(negedge clk) begin
        if (rst_n && done) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R10", "unexpected done", 1, 0);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                check(cyc - t_acc == e.lat, e.tag, "R4 latency", cyc - t_acc, e.lat);
                check(online == e.onl, e.tag, "R5 online", online, e.onl);
                check(clk_en == e.ck, e.tag, "R6 clk_en", clk_en, e.ck);
                check(slave_en == e.s0 && slave_en1 == e.s1, e.tag, "R3 slave ch0/ch1",
                      {slave_en, slave_en1}, {e.s0, e.s1});
                check(!busy && done1 && online1 == e.onl, e.tag, "R10 busy/pair",
                      {busy, done1}, 1);
                @(negedge clk);
                check(!done, "R10", "done width", done, 0);
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        check(1'b0, "watchdog", "timeout", cyc, 0);
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        check({clk_en, chan_rst, ctrl_en, hotplug_en, slave_en, busy, done, online} == 8'd0,
              "R1", "outputs in reset",
              {clk_en, chan_rst, ctrl_en, hotplug_en, slave_en, busy, done, online}, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R9: reserved mode start ignored
        route_mode = 3'd5;
        start_req  = 1'b1;
        @(negedge clk);
        start_req = 1'b0;
        repeat (3) @(negedge clk);
        check(!busy && !clk_en, "R9", "reserved start busy/clk", {busy, clk_en}, 0);

        // R2, R11: first start, control-write timing, stop while busy ignored
        launch(1'b0, 1'b0, 3'd0, 1, "R2 start mode0", 1'b1, 1'b0, 1'b0);
        check(busy && clk_en, "R2", "clk_en at accept", {busy, clk_en}, 3);
        while (cyc < t_acc + W10 - 1) @(negedge clk);
        check(clk_en && !ctrl_en, "R2", "ctrl before settle", ctrl_en, 0);
        @(negedge clk);
        check(ctrl_en && hotplug_en, "R2", "ctrl after settle", {ctrl_en, hotplug_en}, 3);
        stop_req = 1'b1;
        @(negedge clk);
        stop_req = 1'b0;
        @(negedge clk);
        check(clk_en && busy, "R11", "stop while busy ignored", clk_en, 1);
        wait_done();

        // R3: mode 2 makes channel 0 a slave, mode 3 channel 1
        launch(1'b0, 1'b0, 3'd2, 3, "R3 mode2", 1'b1, 1'b1, 1'b0);
        wait_done();
        launch(1'b0, 1'b0, 3'd3, 2, "R3 mode3", 1'b1, 1'b0, 1'b1);
        wait_done();

        // R8: stop in idle clears only the clock
        stop_req = 1'b1;
        @(negedge clk);
        stop_req = 1'b0;
        check(!clk_en && ctrl_en && online && slave_en1, "R8", "stop idle",
              {clk_en, ctrl_en, online, slave_en1}, 7);

        // R5, R6: start that never sees the PHY
        launch(1'b0, 1'b0, 3'd1, 0, "R5 R6 start fail", 1'b0, 1'b0, 1'b0);
        wait_done();

        // R11: start beats a simultaneous stop
        launch(1'b0, 1'b1, 3'd0, 1, "R11 start+stop", 1'b1, 1'b0, 1'b0);
        check(busy && clk_en, "R11", "start priority", {busy, clk_en}, 3);
        wait_done();

        // R7: reset path, one-cycle pulse, clock untouched on failure
        launch(1'b1, 1'b0, 3'd2, 0, "R7 reset fail", 1'b1, 1'b1, 1'b0);
        check(chan_rst && busy, "R7", "reset pulse high", chan_rst, 1);
        @(negedge clk);
        check(!chan_rst && clk_en, "R7", "reset pulse width", chan_rst, 0);
        wait_done();
        launch(1'b1, 1'b0, 3'd0, 2, "R7 reset ok", 1'b1, 1'b0, 1'b0);
        wait_done();

        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule